// File: doc/BRIEF.md
# Pipelined Two-Port Synchronous Static RAM

This block is a word-organised static RAM with two ports, A and B, that are fully independent. Each port has its own clock, synchronous active-low reset, address, write data, write strobe, four lane enables and a pair of chip selects, one active low and one active high. Either port can read or write any word at any time, including the word the other port is using in the same cycle. Every input is captured in a register on the port clock before it is used. The memory is read synchronously, and the result then passes through one more output register, so read data comes out two clock edges after the edge that captured the request.

A port is selected in a cycle only when its active-low select is low and its active-high select is high. In any other cycle the port does nothing. After a deselected cycle, or after reset, the port needs one selected cycle to wake. A read issued in that waking cycle returns nothing, but a write in that cycle is carried out. Read results leave the port as a stream: `rvalid` marks each beat and `rdata` carries it. There is no ready input and so no back-pressure. The consumer has to take every beat in the cycle it is shown. Whenever `rvalid` is low, `rdata` is all zeros.

A word is 36 bits wide and is split into four 9-bit lanes. Lane k occupies bits 9k+8 down to 9k, and lane enable bit k controls it.

Top module: `dpram_pipe`

## Requirements
- R1: After reset, both ports hold `rvalid` low and `rdata` at zero until a read is served.
- R2: A read captured at clock edge n (port selected, write strobe low, previous captured cycle also selected) drives `rvalid` high with the word after edge n+2. `rvalid` stays high for that one cycle only.
- R3: A selected write changes only the lanes whose enable bit is 1 (lane k = bits 9k+8:9k, enable bit k). The other lanes of that word keep their old value.
- R4: A cycle with the active-low select high or the active-high select low is ignored. It does not write, and it produces no read beat.
- R5: The first selected cycle after a deselected cycle or after reset produces no read beat, but a write in that cycle still takes effect.
- R6: While `rvalid` is low, `rdata` is all zeros.
- R7: A word written through one port is returned by a later read on the other port.
- R8: A read on one port and a write on the other port to the same word, captured at the same edge, return the old word to the reader. A read one cycle later returns the new word.
- R9: A write followed by a read of the same word on the same port, in consecutive cycles, returns the new word.
- R10: Both ports can read at the same time, at different words or the same word, including the top address DEPTH-1.
- R11: When both ports write the same word at the same edge, the lanes enabled on both ports are undefined. Lanes enabled on only one port take that port's data, and every other word is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| a_ce0_n | input | 1 | Port A select, active low |
| a_ce1 | input | 1 | Port A select, active high |
| a_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A word address |
| a_be | input | LANES | Port A lane enables |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A read beat, zero when not valid |
| a_rvalid | output | 1 | Port A read beat valid |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| b_ce0_n | input | 1 | Port B select, active low |
| b_ce1 | input | 1 | Port B select, active high |
| b_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B word address |
| b_be | input | LANES | Port B lane enables |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B read beat, zero when not valid |
| b_rvalid | output | 1 | Port B read beat valid |

## Verification
The hardest case to reach from the ports is a read on one port and a write on the other to the same word at the same edge, especially when it is mixed with partial lane masks and a port that has just woken up. A directed sequence arms port A with one read. It then issues A's read and B's write of the same word together and checks both the old word and the new word on the following beats. A long random phase keeps addresses inside a 32-word window, so that cross-port hits, double writes and deselect/wake cycles happen often. A behavioural model checks every beat on every clock and ignores only the lanes that a double write has made undefined.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int NUM_PORTS = 2;

  // A port is selected only with its low-true select low and high-true select high.
  function automatic logic port_selected(input logic sel_lo_n, input logic sel_hi);
    return (!sel_lo_n) && sel_hi;
  endfunction

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_word,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_be,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  // Stage 1: captured request
  logic              cap_sel;
  logic              cap_we;
  logic [ADDR_W-1:0] cap_addr;
  logic [LANES-1:0]  cap_be;
  logic [DATA_W-1:0] cap_wdata;
  // Wake state: set when the previous captured cycle was selected
  logic              awake;
  // Stage 2: array read register
  logic              arr_hit;
  logic [DATA_W-1:0] arr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sel   <= 1'b0;
      cap_we    <= 1'b0;
      cap_addr  <= '0;
      cap_be    <= '0;
      cap_wdata <= '0;
    end else begin
      cap_sel   <= port_selected(ce0_n, ce1);
      cap_we    <= we;
      cap_addr  <= addr;
      cap_be    <= be;
      cap_wdata <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      awake    <= 1'b0;
      arr_hit  <= 1'b0;
      arr_word <= '0;
    end else begin
      awake    <= cap_sel;
      arr_hit  <= cap_sel && !cap_we && awake;
      arr_word <= rd_word;
    end
  end

  // Stage 3: output pipeline register, zeroed while not presenting a beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= arr_hit;
      rdata  <= arr_hit ? arr_word : '0;
    end
  end

  assign acc_wr    = cap_sel && cap_we;
  assign acc_addr  = cap_addr;
  assign acc_be    = cap_be;
  assign acc_wdata = cap_wdata;

endmodule

// File: rtl/dpram_xor_bank.sv
module dpram_xor_bank #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int NRD    = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [LANES-1:0]             wr_be,
  input  logic [DATA_W-1:0]            wr_word,
  input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_q
);

  // One storage array per lane; each has exactly one writing process.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lmem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[l]) begin
        lmem[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
      end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_q[r][l*LANE_W +: LANE_W] = lmem[rd_addr[r]];
    end
  end

endmodule

// File: rtl/dpram_pipe.sv
module dpram_pipe
  import dpram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_ce0_n,
  input  logic              a_ce1,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_ce0_n,
  input  logic              b_ce1,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_be,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  // Per-port views, index 0 = A, 1 = B
  logic [NUM_PORTS-1:0]              p_clk, p_rst_n, p_ce0_n, p_ce1, p_we;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]  p_addr;
  logic [NUM_PORTS-1:0][LANES-1:0]   p_be;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  p_wdata, p_rdata, p_rword;
  logic [NUM_PORTS-1:0]              p_rvalid;

  logic [NUM_PORTS-1:0]              acc_wr;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]  acc_addr;
  logic [NUM_PORTS-1:0][LANES-1:0]   acc_be;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  acc_wdata;

  // bank_q[bank][port]: bank contents at the address captured by each port
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0][DATA_W-1:0] bank_q;

  assign p_clk   = {clk_b,   clk_a};
  assign p_rst_n = {rst_b_n, rst_a_n};
  assign p_ce0_n = {b_ce0_n, a_ce0_n};
  assign p_ce1   = {b_ce1,   a_ce1};
  assign p_we    = {b_we,    a_we};
  assign p_addr  = {b_addr,  a_addr};
  assign p_be    = {b_be,    a_be};
  assign p_wdata = {b_wdata, a_wdata};

  assign a_rdata  = p_rdata[0];
  assign b_rdata  = p_rdata[1];
  assign a_rvalid = p_rvalid[0];
  assign b_rvalid = p_rvalid[1];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam int OTHER = NUM_PORTS - 1 - g;

    // Stored word is the XOR of both banks at the same address.
    assign p_rword[g] = bank_q[0][g] ^ bank_q[1][g];

    dpram_port_ctl #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
    ) ctl_i (
      .clk       (p_clk[g]),
      .rst_n     (p_rst_n[g]),
      .ce0_n     (p_ce0_n[g]),
      .ce1       (p_ce1[g]),
      .we        (p_we[g]),
      .addr      (p_addr[g]),
      .be        (p_be[g]),
      .wdata     (p_wdata[g]),
      .rd_word   (p_rword[g]),
      .acc_wr    (acc_wr[g]),
      .acc_addr  (acc_addr[g]),
      .acc_be    (acc_be[g]),
      .acc_wdata (acc_wdata[g]),
      .rdata     (p_rdata[g]),
      .rvalid    (p_rvalid[g])
    );

    // Bank g is written only by port g; it stores data XOR the other bank.
    dpram_xor_bank #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .NRD    (NUM_PORTS)
    ) bank_i (
      .clk     (p_clk[g]),
      .wr_en   (acc_wr[g]),
      .wr_addr (acc_addr[g]),
      .wr_be   (acc_be[g]),
      .wr_word (acc_wdata[g] ^ bank_q[OTHER][g]),
      .rd_addr (acc_addr),
      .rd_q    (bank_q[g])
    );
  end

endmodule

// File: rtl/dpram_pipe_chk.sv
module dpram_pipe_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_a,
  input logic              rst_a_n,
  input logic              a_ce0_n,
  input logic              a_ce1,
  input logic              a_we,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_rvalid,
  input logic              clk_b,
  input logic              rst_b_n,
  input logic              b_ce0_n,
  input logic              b_ce1,
  input logic              b_we,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_rvalid
);

  logic sel_a, sel_b;
  assign sel_a = !a_ce0_n && a_ce1;
  assign sel_b = !b_ce0_n && b_ce1;

  AST_A_IDLE_ZERO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_rvalid |-> (a_rdata == '0)); // R6

  AST_B_IDLE_ZERO: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_rvalid |-> (b_rdata == '0)); // R6

  AST_A_BEAT_NEEDS_WAKE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    a_rvalid |-> ($past(sel_a, 3) && !$past(a_we, 3) && $past(sel_a, 4))); // R5

  AST_B_BEAT_NEEDS_WAKE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    b_rvalid |-> ($past(sel_b, 3) && !$past(b_we, 3) && $past(sel_b, 4))); // R5

  AST_A_READ_EMERGES: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ($past(rst_a_n, 1) && $past(rst_a_n, 2) && $past(rst_a_n, 3) && $past(rst_a_n, 4)
     && $past(sel_a, 3) && !$past(a_we, 3) && $past(sel_a, 4)) |-> a_rvalid); // R2

  AST_B_READ_EMERGES: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ($past(rst_b_n, 1) && $past(rst_b_n, 2) && $past(rst_b_n, 3) && $past(rst_b_n, 4)
     && $past(sel_b, 3) && !$past(b_we, 3) && $past(sel_b, 4)) |-> b_rvalid); // R2

endmodule

bind dpram_pipe dpram_pipe_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpram_pipe_tb_top.sv
module dpram_pipe_tb_top;

  localparam int DEPTH  = 1024;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int AW     = 10;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [1:0]    ce0_n, ce1, we;
  logic [AW-1:0] addr [2];
  logic [LANES-1:0] be [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];
  logic [1:0]    rv;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  dpram_pipe #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk_a(clk), .rst_a_n(rst_n), .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_we(we[0]),
    .a_addr(addr[0]), .a_be(be[0]), .a_wdata(wd[0]), .a_rdata(rd[0]), .a_rvalid(rv[0]),
    .clk_b(clk), .rst_b_n(rst_n), .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_we(we[1]),
    .b_addr(addr[1]), .b_be(be[1]), .b_wdata(wd[1]), .b_rdata(rd[1]), .b_rvalid(rv[1])
  );

  function automatic logic [DW-1:0] lanebits(input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: LANE_W] = {LANE_W{m[l]}};
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0]    rm [DEPTH];
  logic [LANES-1:0] rx [DEPTH];
  bit m_sel [2], m_we [2], m_awake [2];
  logic [AW-1:0] m_addr [2];
  logic [LANES-1:0] m_be [2];
  logic [DW-1:0] m_wd [2];
  bit st_v [2], ex_v [2];
  logic [DW-1:0] st_d [2], ex_d [2];
  logic [LANES-1:0] st_x [2], ex_x [2];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rm[i] = '0;
      rx[i] = '1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_sel[p] = 0; m_awake[p] = 0; m_we[p] = 0;
        st_v[p] = 0; st_d[p] = '0; st_x[p] = '0;
        ex_v[p] = 0; ex_d[p] = '0; ex_x[p] = '0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        ex_v[p] = st_v[p]; ex_d[p] = st_d[p]; ex_x[p] = st_x[p];
      end
      for (int p = 0; p < 2; p++) begin
        if (m_sel[p] && !m_we[p] && m_awake[p]) begin
          st_v[p] = 1; st_d[p] = rm[m_addr[p]]; st_x[p] = rx[m_addr[p]];
        end else begin
          st_v[p] = 0; st_d[p] = '0; st_x[p] = '0;
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (m_sel[p] && m_we[p]) begin
          for (int l = 0; l < LANES; l++) begin
            if (m_be[p][l]) begin
              rm[m_addr[p]][l*LANE_W +: LANE_W] = m_wd[p][l*LANE_W +: LANE_W];
              rx[m_addr[p]][l] = 1'b0;
            end
          end
        end
      end
      if (m_sel[0] && m_we[0] && m_sel[1] && m_we[1] && m_addr[0] == m_addr[1])
        rx[m_addr[0]] = rx[m_addr[0]] | (m_be[0] & m_be[1]);
      for (int p = 0; p < 2; p++) begin
        m_awake[p] = m_sel[p];
        m_sel[p]   = !ce0_n[p] && ce1[p];
        m_we[p]    = we[p];
        m_addr[p]  = addr[p];
        m_be[p]    = be[p];
        m_wd[p]    = wd[p];
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int p = 0; p < 2; p++) begin
        logic [DW-1:0] mask;
        mask = ~lanebits(ex_x[p]);
        checks++;
        if (rv[p] !== ex_v[p] || ((rd[p] ^ ex_d[p]) & mask) != '0) begin
          errors++;
          $display("FAIL %s port %0d: got valid=%0b data=%h, expected valid=%0b data=%h",
                   ex_v[p] ? tag : "R6", p, rv[p], rd[p], ex_v[p], ex_d[p]);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input int p, input bit lo_n, input bit hi, input bit w,
                     input int a, input logic [LANES-1:0] b, input logic [DW-1:0] d);
    ce0_n[p] = lo_n; ce1[p] = hi; we[p] = w;
    addr[p] = AW'(a); be[p] = b; wd[p] = d;
  endtask

  task automatic idle(input int p);
    drv(p, 1'b1, 1'b0, 1'b0, 0, '0, '0);
  endtask

  task automatic rd_(input int p, input int a);
    drv(p, 1'b0, 1'b1, 1'b0, a, '0, '0);
  endtask

  task automatic wr_(input int p, input int a, input logic [LANES-1:0] b, input logic [DW-1:0] d);
    drv(p, 1'b0, 1'b1, 1'b1, a, b, d);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Two reads of one word (first arms the port), then check the second beat.
  task automatic peek(input int p, input int a, input logic [DW-1:0] exp,
                      input logic [DW-1:0] care, input string t);
    rd_(p, a); tick();
    rd_(p, a); tick();
    idle(p); tick();
    tick();
    chk(rv[p] === 1'b1 && ((rd[p] ^ exp) & care) == '0, t, rd[p], exp);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [DW-1:0] w0, d0;
    idle(0); idle(1);
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tag = "R1";
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(rv == 2'b00 && rd[0] == '0 && rd[1] == '0, "R1", rd[0], '0);
    end

    // Fill words 0..15 from port A; the first (waking) write must land (R5)
    tag = "R9";
    for (int i = 0; i < 16; i++) begin
      wr_(0, i, 4'hF, DW'(36'h1_0000_0000 + i * 36'h0_0101_0101));
      tick();
    end
    idle(0); tick();
    peek(0, 0, DW'(36'h1_0000_0000), '1, "R5");
    wr_(0, 20, 4'hF, DW'(36'hA_BCDE_F012)); tick();
    rd_(0, 20); tick();
    idle(0); tick(); tick();
    chk(rv[0] === 1'b1 && rd[0] == DW'(36'hA_BCDE_F012), "R9", rd[0], DW'(36'hA_BCDE_F012));

    // Lane masking through port B (R3), cross-port visibility (R7)
    tag = "R3";
    w0 = DW'(36'h1_0000_0000 + 7 * 36'h0_0101_0101);
    d0 = DW'(36'hF_FFFF_FFFF);
    wr_(1, 7, 4'b0101, d0); tick();
    idle(1); tick();
    peek(0, 7, (d0 & lanebits(4'b0101)) | (w0 & ~lanebits(4'b0101)), '1, "R3");
    tag = "R7";
    peek(1, 3, DW'(36'h1_0000_0000 + 3 * 36'h0_0101_0101), '1, "R7");

    // Deselected writes are ignored (R4)
    tag = "R4";
    drv(0, 1'b1, 1'b1, 1'b1, 4, 4'hF, '0); tick();
    drv(0, 1'b0, 1'b0, 1'b1, 4, 4'hF, '0); tick();
    idle(0); tick();
    peek(0, 4, DW'(36'h1_0000_0000 + 4 * 36'h0_0101_0101), '1, "R4");

    // Wake rule: read right after a deselect gives no beat (R5)
    tag = "R5";
    idle(0); tick();
    rd_(0, 2); tick();
    idle(0); tick(); tick();
    chk(rv[0] === 1'b0 && rd[0] == '0, "R5", rd[0], '0);

    // Same-edge read on A and write on B to word 5 (R8)
    tag = "R8";
    w0 = DW'(36'h1_0000_0000 + 5 * 36'h0_0101_0101);
    rd_(0, 5); idle(1); tick();
    rd_(0, 5); wr_(1, 5, 4'hF, DW'(36'h5_5555_5555)); tick();
    rd_(0, 5); idle(1); tick();
    idle(0); tick();
    chk(rv[0] === 1'b1 && rd[0] == w0, "R8", rd[0], w0);
    tick();
    chk(rv[0] === 1'b1 && rd[0] == DW'(36'h5_5555_5555), "R8", rd[0], DW'(36'h5_5555_5555));

    // Simultaneous reads, same word and the top address (R10)
    tag = "R10";
    wr_(1, DEPTH - 1, 4'hF, DW'(36'h9_8765_4321)); tick();
    idle(1); tick();
    rd_(0, 6); rd_(1, 6); tick();
    rd_(0, DEPTH - 1); rd_(1, DEPTH - 1); tick();
    idle(0); idle(1); tick(); tick();
    chk(rv == 2'b11 && rd[0] == DW'(36'h9_8765_4321) && rd[1] == DW'(36'h9_8765_4321),
        "R10", rd[1], DW'(36'h9_8765_4321));

    // Double write to word 9: lane 1 overlaps, others defined (R11)
    tag = "R11";
    w0 = DW'(36'h1_0000_0000 + 9 * 36'h0_0101_0101);
    wr_(0, 9, 4'b0011, DW'(36'h0_0000_0AAA)); wr_(1, 9, 4'b0110, DW'(36'h0_0BBB_BBBB)); tick();
    idle(0); idle(1); tick();
    d0 = (DW'(36'h0_0000_0AAA) & lanebits(4'b0001)) | (DW'(36'h0_0BBB_BBBB) & lanebits(4'b0100))
       | (w0 & lanebits(4'b1000));
    peek(0, 9, d0, ~lanebits(4'b0010), "R11");
    peek(1, 8, DW'(36'h1_0000_0000 + 8 * 36'h0_0101_0101), '1, "R11");
    peek(0, 10, DW'(36'h1_0000_0000 + 10 * 36'h0_0101_0101), '1, "R11");

    // Random traffic in a small window, checked every cycle by the model (R2)
    tag = "R2";
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < 2; p++) begin
        drv(p, ($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2,
            int'($urandom % 32), LANES'($urandom), {$urandom, $urandom});
      end
      tick();
    end
    idle(0); idle(1);
    repeat (4) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule